// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block models a byte-wide serial EEPROM that sits on a two-wire (I2C-style) bus as a target device. The block oversamples the bus clock and data lines with its own system clock. It finds start and stop conditions and checks the device address word against two select pins, so up to four copies can share one bus. It then runs one of several transfers. A write carries a two-byte word address and one to sixty-four data bytes. A read comes in one of three forms, all built on one internal address counter: it reads from the current counter, from a newly loaded address, or through a run of bytes.

Written bytes are collected in a one-page buffer. They reach the array only when the controller ends the write with a stop and the write-protect input is low. A committed write starts a self-timed busy period. The period is `WR_CYCLES` system clocks, which stands for roughly 5 ms. During it the device does not acknowledge its address. The bus output is a single open-drain pull-down request: when it is high, the pad pulls SDA low.

Top module: `twowire_eeprom`

## Requirements
- R1: After reset, and whenever the device is not taking part in a transfer, `sda_pull_o` is low (SDA released).
- R2: The byte after a start is the device address word: bits 7..3 must be 10100, bits 2..1 must equal `sel_i`, and bit 0 is 1 for a read. On a match while not busy, the device pulls SDA low during the ninth clock. On a mismatch it gives no acknowledge and does not drive SDA until the next start.
- R3: A write carries a 15-bit word address as two bytes, high byte first. Bit 7 of the high byte is ignored. Both bytes are acknowledged.
- R4: Every write data byte is acknowledged. A stop with `wprot_i` low stores every byte received, whether one byte or up to a full page of 64.
- R5: During a write only address bits 5..0 advance, so bytes past the end of a 64-byte page wrap to the start of the same page.
- R6: For `WR_CYCLES` clocks after a stop that commits data, the device acknowledges no address word.
- R7: If `wprot_i` is high at the stop, the array is left unchanged. Data bytes are still acknowledged.
- R8: A current address read returns the byte at the address one past the last byte read or written.
- R9: A random read loads the word address with a write header, then reads after a repeated start. The first byte returned comes from the loaded address.
- R10: While the controller acknowledges, a read continues with the next byte. The full 15-bit address increments and wraps from 0x7FFF to 0x0000.
- R11: When the controller does not acknowledge a read byte, the device releases SDA and drives nothing more until a new start.
- R12: Data is sent MSB first. The device changes `sda_pull_o` only while the sampled SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sel_i | input | 2 | Device select pins compared with address bits 2..1 |
| wprot_i | input | 1 | Write protect; high blocks array updates |
| sda_pull_o | output | 1 | High requests the pad to pull SDA low |

## Verification
A wrong bit counter or state shows on the bus within one byte. An acknowledge pulse lands on the wrong clock, or a data bit comes out shifted, and the per-clock comparison of `sda_pull_o` against the model's expected level catches it within a few system clocks. A wrong address counter or page offset is silent while data is written. It appears in the first byte read back from the affected location, which the model predicts from its own memory image. A busy timer that is wrong appears at the first address word sent after a write, as a missing or unexpected acknowledge.

// File: rtl/twowire_eeprom.sv
module twowire_eeprom #(
  parameter int ADDR_W    = 15,
  parameter int MEM_AW    = 12,
  parameter int PAGE_AW   = 6,
  parameter int WR_CYCLES = 500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] sel_i,
  input  logic       wprot_i,
  output logic       sda_pull_o
);
  localparam int PAGE_N = 1 << PAGE_AW;
  localparam int MEM_N  = 1 << MEM_AW;
  localparam int CW     = $clog2(WR_CYCLES + 1);
  localparam int HI_W   = ADDR_W - 8;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_AH, S_AL, S_WR, S_RD} st_t;

  logic [2:0]        scl_p, sda_p;
  st_t               st;
  logic [3:0]        bitc;
  logic [7:0]        sh;
  logic              ack_drv, rd_drive;
  logic [ADDR_W-1:0] addr;
  logic [HI_W-1:0]   ahi;
  logic [PAGE_N-1:0] pval;
  logic [CW-1:0]     wcnt;
  logic [7:0]        pbuf [PAGE_N];
  logic [7:0]        mem  [MEM_N];

  logic scl_s, scl_d, sda_s, sda_d;
  assign scl_s = scl_p[1];
  assign scl_d = scl_p[2];
  assign sda_s = sda_p[1];
  assign sda_d = sda_p[2];

  logic rise, fall, start, stop, busy, idle, dev_hit, commit, byte_in;
  assign rise    = scl_s & ~scl_d;
  assign fall    = ~scl_s & scl_d;
  assign start   = scl_s & scl_d & sda_d & ~sda_s;
  assign stop    = scl_s & scl_d & ~sda_d & sda_s;
  assign busy    = wcnt != '0;
  assign idle    = st == S_IDLE;
  assign dev_hit = sh[7:3] == 5'b10100 && sh[2:1] == sel_i && !busy;
  assign commit  = stop && st == S_WR && |pval && !wprot_i;
  assign byte_in = fall && bitc == 4'd8 && st == S_WR;

  logic [7:0] rdata;
  assign rdata      = mem[addr[MEM_AW-1:0]];
  assign sda_pull_o = ack_drv | (rd_drive & ~sh[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      bitc     <= '0;
      sh       <= '0;
      ack_drv  <= 1'b0;
      rd_drive <= 1'b0;
      addr     <= '0;
      ahi      <= '0;
      pval     <= '0;
    end else if (start || stop) begin
      st       <= start ? S_DEV : S_IDLE;
      bitc     <= '0;
      ack_drv  <= 1'b0;
      rd_drive <= 1'b0;
    end else if (!idle) begin
      if (rise) begin
        if (bitc == 4'd8) begin
          bitc <= '0;
          if (st == S_RD && sda_s) st <= S_IDLE;
        end else begin
          bitc <= bitc + 4'd1;
          if (st != S_RD) sh <= {sh[6:0], sda_s};
        end
      end else if (fall) begin
        if (bitc == 4'd8) begin
          if (st == S_RD) rd_drive <= 1'b0;
          else begin
            ack_drv <= 1'b1;
            case (st)
              S_DEV: if (!dev_hit) begin
                       ack_drv <= 1'b0;
                       st      <= S_IDLE;
                     end else st <= sh[0] ? S_RD : S_AH;
              S_AH:  begin ahi <= sh[HI_W-1:0]; st <= S_AL; end
              S_AL:  begin addr <= {ahi, sh}; pval <= '0; st <= S_WR; end
              default: begin
                pval[addr[PAGE_AW-1:0]] <= 1'b1;
                addr <= {addr[ADDR_W-1:PAGE_AW], addr[PAGE_AW-1:0] + 1'b1};
              end
            endcase
          end
        end else if (bitc == 4'd0) begin
          ack_drv <= 1'b0;
          if (st == S_RD) begin
            sh       <= rdata;
            rd_drive <= 1'b1;
            addr     <= addr + 1'b1;
          end
        end else if (st == S_RD) sh <= {sh[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (byte_in) pbuf[addr[PAGE_AW-1:0]] <= sh;
    if (commit)
      for (int i = 0; i < PAGE_N; i++)
        if (pval[i]) mem[{addr[MEM_AW-1:PAGE_AW], i[PAGE_AW-1:0]}] <= pbuf[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wcnt <= '0;
    else if (commit) wcnt <= CW'(WR_CYCLES);
    else if (busy)   wcnt <= wcnt - 1'b1;
  end
endmodule

module twowire_eeprom_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic idle,
  input logic busy,
  input logic wprot_i,
  input logic sda_pull_o
);
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_pull_o) else $error("idle drive"); // R1
  AST_DRIVE_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_s) else $error("drive while SCL high"); // R12
  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_pull_o) else $error("drive while busy"); // R6
  AST_COMMIT_UNPROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wprot_i)) else $error("write under protect"); // R7
endmodule

bind twowire_eeprom twowire_eeprom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .idle(idle), .busy(busy),
  .wprot_i(wprot_i), .sda_pull_o(sda_pull_o)
);

// File: tb/tb_twowire_eeprom.sv
module tb_twowire_eeprom;
  localparam int CLK_P  = 10;
  localparam int MAW    = 12;
  localparam int WRC    = 300;
  localparam logic [1:0] SEL = 2'b01;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1, wprot = 1'b0;
  logic sda_pull, sda_bus;
  assign sda_bus = m_sda & ~sda_pull;
  always #(CLK_P/2) clk = ~clk;

  twowire_eeprom #(.MEM_AW(MAW), .WR_CYCLES(WRC)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sel_i(SEL),
    .wprot_i(wprot), .sda_pull_o(sda_pull));

  int n_chk = 0, n_fail = 0;
  logic exp_on = 1'b0, exp_pull = 1'b0;
  string exp_tag = "R1";
  logic [7:0] ref_mem [int];
  int m_addr = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always begin
    @(posedge clk);
    #(CLK_P/4);
    if (exp_on) chk(sda_pull == exp_pull, exp_tag, sda_pull, exp_pull);
  end

  function automatic int key(input int a);
    return a & ((1 << MAW) - 1);
  endfunction

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_slot(input logic mbit, input logic ep, input string tag, output logic seen);
    exp_on = 1'b0;
    wclk(5);
    m_sda = mbit; exp_pull = ep; exp_tag = tag; exp_on = 1'b1;
    wclk(3);
    scl = 1'b1;
    wclk(4);
    seen = sda_bus;
    wclk(4);
    scl = 1'b0;
  endtask

  task automatic start_c();
    exp_on = 1'b0;
    m_sda = 1'b1; wclk(4);
    scl = 1'b1;   wclk(6);
    m_sda = 1'b0; wclk(6);
    scl = 1'b0;
  endtask

  task automatic stop_c();
    exp_on = 1'b0;
    wclk(4); m_sda = 1'b0;
    wclk(4); scl = 1'b1;
    wclk(6); m_sda = 1'b1;
    wclk(6);
    exp_pull = 1'b0; exp_tag = "R1 released after stop"; exp_on = 1'b1;
    wclk(4);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic ack, input string tag);
    logic seen;
    for (int i = 7; i >= 0; i--) bit_slot(b[i], 1'b0, tag, seen);
    bit_slot(1'b1, ack, tag, seen);
    chk(seen == !ack, tag, seen, !ack);
  endtask

  task automatic recv_byte(input logic [7:0] eb, input logic mack, input string tag);
    logic seen;
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      bit_slot(1'b1, ~eb[i], tag, seen);
      got[i] = seen;
    end
    chk(got == eb, tag, got, eb);
    bit_slot(!mack, 1'b0, tag, seen);
  endtask

  task automatic do_write(input int a, input logic [7:0] d[$], input logic wp);
    wprot = wp;
    start_c();
    send_byte({5'b10100, SEL, 1'b0}, 1'b1, "R2 write header ack");
    send_byte({1'b1, 7'(a >> 8)}, 1'b1, "R3 high address ack, bit7 ignored");
    send_byte(8'(a), 1'b1, "R3 low address ack");
    foreach (d[k]) send_byte(d[k], 1'b1, wp ? "R7 protected byte ack" : "R4 data ack");
    stop_c();
    for (int k = 0; k < d.size(); k++) begin
      int wa = (a & 32'h7FC0) | ((a + k) & 32'h3F);
      if (!wp) ref_mem[key(wa)] = d[k];
    end
    m_addr = (a & 32'h7FC0) | ((a + d.size()) & 32'h3F);
    wprot = 1'b0;
  endtask

  task automatic rd_seq(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      recv_byte(ref_mem[key(m_addr)], k != n - 1, tag);
      m_addr = (m_addr + 1) & 32'h7FFF;
    end
  endtask

  task automatic rd_random(input int a, input int n, input string tag);
    start_c();
    send_byte({5'b10100, SEL, 1'b0}, 1'b1, "R9 dummy write header");
    send_byte(8'(a >> 8), 1'b1, "R9 address high");
    send_byte(8'(a), 1'b1, "R9 address low");
    start_c();
    send_byte({5'b10100, SEL, 1'b1}, 1'b1, "R2 read header ack");
    m_addr = a;
    rd_seq(n, tag);
    stop_c();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic seen;
    wclk(5);
    rst_n = 1'b1;
    wclk(3);
    chk(sda_pull == 1'b0, "R1 reset released", sda_pull, 0);

    do_write(32'h0045, '{8'hA5}, 1'b0);
    start_c();
    send_byte({5'b10100, SEL, 1'b0}, 1'b0, "R6 busy no ack");
    stop_c();
    wclk(WRC + 20);
    rd_random(32'h0045, 1, "R9 random read byte");

    do_write(32'h013E, '{8'h11, 8'h22, 8'h33, 8'h44}, 1'b0);
    wclk(WRC + 20);
    rd_random(32'h013E, 2, "R5 page tail");
    rd_random(32'h0100, 1, "R5 page wrapped head");
    start_c();
    send_byte({5'b10100, SEL, 1'b1}, 1'b1, "R8 current read header");
    rd_seq(1, "R8 current address read");
    stop_c();

    begin
      logic [7:0] pg[$];
      for (int i = 0; i < 64; i++) pg.push_back(8'(i * 3 + 1));
      do_write(32'h0200, pg, 1'b0);
    end
    wclk(WRC + 20);
    rd_random(32'h0200, 64, "R4 R10 full page sequential");

    do_write(32'h7FFE, '{8'h9A, 8'h9B}, 1'b0);
    wclk(WRC + 20);
    do_write(32'h0000, '{8'hC0, 8'hC1}, 1'b0);
    wclk(WRC + 20);
    rd_random(32'h7FFE, 4, "R10 wrap 7FFF to 0");

    do_write(32'h0045, '{8'h5A}, 1'b1);
    start_c();
    send_byte({5'b10100, SEL, 1'b0}, 1'b1, "R7 no busy after protected write");
    stop_c();
    rd_random(32'h0045, 1, "R7 protected byte unchanged");

    start_c();
    send_byte({5'b10100, ~SEL, 1'b1}, 1'b0, "R2 wrong select no ack");
    send_byte(8'h00, 1'b0, "R2 silent until start");
    stop_c();
    start_c();
    send_byte({5'b00100, SEL, 1'b1}, 1'b0, "R2 wrong fixed bits no ack");
    stop_c();

    rd_random(32'h0045, 1, "R11 nack read");
    start_c();
    send_byte({5'b10100, SEL, 1'b0}, 1'b1, "R11 header");
    send_byte(8'h00, 1'b1, "R11 addr hi");
    send_byte(8'h45, 1'b1, "R11 addr lo");
    start_c();
    send_byte({5'b10100, SEL, 1'b1}, 1'b1, "R11 read header");
    recv_byte(8'hA5, 1'b0, "R11 last byte");
    for (int i = 0; i < 9; i++) bit_slot(1'b1, 1'b0, "R11 released after nack", seen);
    stop_c();
    chk(sda_pull == 1'b0, "R1 idle at end", sda_pull, 0);
    finish_run();
  end
endmodule